// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Word Crossing

This block carries one data word from a sending clock domain into a receiving clock domain that has no fixed relation to it. The sender registers the word onto a shared bus and holds it there. It then raises a single request line. That line passes through a two-flop synchronizer into the receiving domain. When the receiver sees the synchronized request, it samples the bus directly, because the protocol guarantees the bus is quiet at that point. It then raises an acknowledge line, which passes back through its own two-flop synchronizer.

The exchange ends in two steps. The sender drops its request once the synchronized acknowledge arrives. The receiver then drops its acknowledge. The sender stays busy until the acknowledge has been seen low again. Only one word is in flight at a time, so every word costs one full round trip through both synchronizers. On the receiving side each word appears together with a strobe that lasts exactly one receive-clock cycle.

Top module: `xfer_hs4`

## Requirements
- R1: While either reset is held low, `snd_busy` reads 0 and `rcv_valid` reads 0.
- R2: Every accepted word appears on `rcv_data` with the same value, and words arrive in the order they were accepted.
- R3: `rcv_valid` is high for exactly one `clk_b` cycle per accepted word and is never high on two consecutive `clk_b` cycles.
- R4: A high `snd_valid` while `snd_busy` is 0 is accepted, and `snd_busy` reads 1 from the next `clk_a` cycle. A high `snd_valid` while `snd_busy` is 1 is ignored: it produces no extra word and does not alter the word in flight.
- R5: From the cycle after acceptance until `snd_busy` falls, the crossing bus keeps the accepted value, even if `snd_data` changes.
- R6: The request rises one `clk_a` cycle after the bus is loaded, with the bus already stable. The request falls only after the synchronized acknowledge has been seen high.
- R7: The acknowledge rises only in the `clk_b` cycle after the word was latched. It falls only after the synchronized request has been seen low.
- R8: `snd_busy` falls only after the synchronized acknowledge has been seen low. By that time the word has already been delivered on the receive side.
- R9: Each transfer keeps `snd_busy` high for at least 5 `clk_a` cycles, because it needs a full round trip through both synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sending-domain clock |
| rst_a_n | input | 1 | Sending-domain synchronous reset, active low |
| snd_valid | input | 1 | Request to send `snd_data` |
| snd_data | input | W (16) | Word to send |
| snd_busy | output | 1 | Transfer in progress; new requests are ignored |
| clk_b | input | 1 | Receiving-domain clock |
| rst_b_n | input | 1 | Receiving-domain synchronous reset, active low |
| rcv_valid | output | 1 | One-cycle strobe marking a newly latched word |
| rcv_data | output | W (16) | Most recently latched word |

## Verification
The hardest situation to provoke is a lost, duplicated or corrupted word. That only happens when the request and acknowledge edges fall at awkward phases between the two clocks, while the sender is also being pushed with new requests and changing data in the middle of a transfer. The stimulus sweeps the receive clock over six half-periods, from much faster to much slower than the send clock, and varies the idle gap between sends. On every third transfer it pulses `snd_valid` with a foreign word while busy, and it scrambles `snd_data` for the whole transfer. Any capture of the live input or acceptance of a second request then shows up as a wrong or extra received word.

// File: rtl/xfer_hs4_pkg.sv
`timescale 1ns/1ps
// Shared state encodings for the four-phase word crossing.
package xfer_hs4_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOAD = 2'd1,
        TX_REQ  = 2'd2,
        TX_DROP = 2'd3
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_WAIT = 2'd0,
        RX_CAP  = 2'd1,
        RX_ACK  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/xfer_hs4_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer for one control bit.
// Assumes: d_in is a level that stays put for several destination cycles;
// STAGES >= 2.
module xfer_hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOP-1:0], d_in};
    end

    assign d_out = chain[TOP];
endmodule

// File: rtl/xfer_hs4_tx.sv
`timescale 1ns/1ps
// Sending side: accepts a word, drives it onto the crossing bus, and runs
// the request half of the four-phase exchange.
// Assumes: ack_s is already synchronized into clk.
module xfer_hs4_tx
    import xfer_hs4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         snd_valid,
    input  logic [W-1:0] snd_data,
    output logic         snd_busy,
    input  logic         ack_s,
    output logic         req,
    output logic [W-1:0] bus
);
    tx_state_t state;

    // Sequence load -> request -> release and hold the bus throughout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            req   <= 1'b0;
            bus   <= '0;
        end else begin
            case (state)
                TX_IDLE: if (snd_valid && !ack_s) begin
                    bus   <= snd_data;
                    state <= TX_LOAD;
                end
                TX_LOAD: begin
                    req   <= 1'b1;
                    state <= TX_REQ;
                end
                TX_REQ: if (ack_s) begin
                    req   <= 1'b0;
                    state <= TX_DROP;
                end
                default: if (!ack_s) state <= TX_IDLE;
            endcase
        end
    end

    // Busy covers every phase from acceptance until ack is seen low.
    assign snd_busy = (state != TX_IDLE);

    p_bus_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_busy && $past(snd_busy)) |-> $stable(bus));

    p_data_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $stable(bus));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_s));

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snd_busy) |-> !$past(ack_s));
endmodule

// File: rtl/xfer_hs4_rx.sv
`timescale 1ns/1ps
// Receiving side: latches the quiet bus on synchronized request, emits a
// one-cycle strobe, then runs the acknowledge half of the exchange.
// Assumes: req_s is already synchronized into clk and bus is stable
// whenever req_s is high.
module xfer_hs4_rx
    import xfer_hs4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_s,
    input  logic [W-1:0] bus,
    output logic         ack,
    output logic         rcv_valid,
    output logic [W-1:0] rcv_data
);
    rx_state_t state;

    // Capture the word, then raise ack, then wait for the request to clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_WAIT;
            ack      <= 1'b0;
            rcv_data <= '0;
        end else begin
            case (state)
                RX_WAIT: if (req_s) begin
                    rcv_data <= bus;
                    state    <= RX_CAP;
                end
                RX_CAP: begin
                    ack   <= 1'b1;
                    state <= RX_ACK;
                end
                default: if (!req_s) begin
                    ack   <= 1'b0;
                    state <= RX_WAIT;
                end
            endcase
        end
    end

    // The strobe marks the single cycle right after the latch.
    assign rcv_valid = (state == RX_CAP);

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_valid |=> !rcv_valid);

    p_ack_after_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(rcv_valid));

    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(req_s));
endmodule

// File: rtl/xfer_hs4.sv
`timescale 1ns/1ps
// Top: single-word crossing between two unrelated clocks using a
// four-phase request/acknowledge exchange. Only req and ack are
// synchronized; the data bus crosses unsynchronized and relies on the
// protocol to keep it stable while it is sampled.
// Assumes: each reset is synchronous to its own clock, and both resets
// are released before traffic starts.
module xfer_hs4 #(
    parameter int W          = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk_a,
    input  logic         rst_a_n,
    input  logic         snd_valid,
    input  logic [W-1:0] snd_data,
    output logic         snd_busy,
    input  logic         clk_b,
    input  logic         rst_b_n,
    output logic         rcv_valid,
    output logic [W-1:0] rcv_data
);
    logic         req_a;
    logic         req_b_s;
    logic         ack_b;
    logic         ack_a_s;
    logic [W-1:0] bus_a;

    xfer_hs4_tx #(.W(W)) tx_i (
        .clk       (clk_a),
        .rst_n     (rst_a_n),
        .snd_valid (snd_valid),
        .snd_data  (snd_data),
        .snd_busy  (snd_busy),
        .ack_s     (ack_a_s),
        .req       (req_a),
        .bus       (bus_a)
    );

    xfer_hs4_sync #(.STAGES(SYNC_DEPTH)) req_sync_i (
        .clk   (clk_b),
        .rst_n (rst_b_n),
        .d_in  (req_a),
        .d_out (req_b_s)
    );

    xfer_hs4_rx #(.W(W)) rx_i (
        .clk       (clk_b),
        .rst_n     (rst_b_n),
        .req_s     (req_b_s),
        .bus       (bus_a),
        .ack       (ack_b),
        .rcv_valid (rcv_valid),
        .rcv_data  (rcv_data)
    );

    xfer_hs4_sync #(.STAGES(SYNC_DEPTH)) ack_sync_i (
        .clk   (clk_a),
        .rst_n (rst_a_n),
        .d_in  (ack_b),
        .d_out (ack_a_s)
    );
endmodule

// File: tb/xfer_hs4_tb_top.sv
`timescale 1ns/1ps
module xfer_hs4_tb_top;
    localparam int W = 16;

    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         rst_a_n = 1'b0;
    logic         rst_b_n = 1'b0;
    logic         snd_valid = 1'b0;
    logic [W-1:0] snd_data = '0;
    logic         snd_busy;
    logic         rcv_valid;
    logic [W-1:0] rcv_data;

    real hb_b = 5.0;

    int total = 0;
    int bad = 0;
    logic [W-1:0] sent [0:511];
    int n_sent = 0;
    int n_rcvd = 0;
    logic prev_v = 1'b0;

    xfer_hs4 #(.W(W)) dut_i (
        .clk_a     (clk_a),
        .rst_a_n   (rst_a_n),
        .snd_valid (snd_valid),
        .snd_data  (snd_data),
        .snd_busy  (snd_busy),
        .clk_b     (clk_b),
        .rst_b_n   (rst_b_n),
        .rcv_valid (rcv_valid),
        .rcv_data  (rcv_data)
    );

    always #4 clk_a = ~clk_a;
    always begin
        #(hb_b);
        clk_b = ~clk_b;
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Receive monitor: order, value and strobe width (R2, R3, R4).
    always @(negedge clk_b) begin
        if (rst_b_n) begin
            if (rcv_valid) begin
                check(!prev_v, "R3 strobe width", int'(prev_v), 0);
                if (n_rcvd < n_sent)
                    check(rcv_data == sent[n_rcvd], "R2 word value",
                          int'(rcv_data), int'(sent[n_rcvd]));
                else
                    check(1'b0, "R4 extra word", int'(rcv_data), 0);
                n_rcvd++;
            end
            prev_v = rcv_valid;
        end
    end

    task automatic send_word(input logic [W-1:0] w, input bit inject);
        int cyc;
        @(negedge clk_a);
        snd_valid = 1'b1;
        snd_data  = w;
        sent[n_sent] = w;
        n_sent++;
        @(negedge clk_a);
        snd_valid = 1'b0;
        snd_data  = ~w;
        check(snd_busy == 1'b1, "R4 busy after accept", int'(snd_busy), 1);
        cyc = 1;
        while (snd_busy) begin
            if (inject && cyc == 2) begin
                snd_valid = 1'b1;
                snd_data  = 16'hA5A5;
            end else begin
                snd_valid = 1'b0;
                snd_data  = w ^ W'(cyc * 16'h0101);
            end
            @(negedge clk_a);
            cyc++;
        end
        snd_valid = 1'b0;
        check(cyc >= 5, "R9 round-trip length", cyc, 5);
        check(n_rcvd == n_sent, "R8 delivered before busy drops", n_rcvd, n_sent);
    endtask

    initial begin
        #1_500_000;
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        real hbs [6];
        hbs = '{1.5, 2.5, 4.0, 6.5, 11.0, 17.0};
        repeat (8) @(negedge clk_b);
        @(negedge clk_a);
        check(snd_busy == 1'b0, "R1 busy in reset", int'(snd_busy), 0);
        check(rcv_valid == 1'b0, "R1 strobe in reset", int'(rcv_valid), 0);
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        repeat (4) @(negedge clk_a);
        check(snd_busy == 1'b0, "R1 idle after reset", int'(snd_busy), 0);

        for (int c = 0; c < 6; c++) begin
            hb_b = hbs[c];
            repeat (3) @(negedge clk_a);
            for (int k = 0; k < 20; k++) begin
                logic [W-1:0] w;
                if (k == 0)      w = 16'hFFFF;
                else if (k == 1) w = 16'h0000;
                else             w = W'(k * 16'h2F1B + c * 16'h0911) ^ W'(1 << (k % W));
                send_word(w, (k % 3) == 0);
                repeat (k % 4) @(negedge clk_a);
            end
            repeat (40) @(negedge clk_a);
            check(n_rcvd == n_sent, "R2 word count", n_rcvd, n_sent);
            check(snd_busy == 1'b0, "R4 idle after sweep", int'(snd_busy), 0);
        end
        report();
    end
endmodule